// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that gives a host access to a byte-addressed register space through an internal register pointer. It oversamples SCL and SDA in the system clock domain, recognises START, repeated START and STOP, and compares the received 7-bit device address with its own. It pulls SDA low only to acknowledge and to send read data, and never drives it high.

In a write transfer, the first byte after the address loads the pointer. Each later byte is stored through a simple register-file port at the pointer, and the pointer then advances. Only a small window of locations accepts stored data. A read transfer streams bytes from the pointer onward. Each byte is taken from the register file at the moment its transmission begins, and the transfer continues for as long as the host acknowledges. The pointer keeps its value after a STOP, so a later read can begin without setting it again.

The register file sits outside the block. Its read data must follow `reg_addr` combinationally or within one clock.

Top module: `i2c_regslave`

## Requirements
- R1: The block acknowledges a received address byte whose upper seven bits equal `DEV_ADDR`. For any other address it leaves SDA released until the next START or STOP.
- R2: The first byte after an address with the write bit (bit 0 = 0) sets the pointer and is acknowledged only when it is below 0x80. A byte of 0x80 or above is not acknowledged and leaves the pointer unchanged.
- R3: A data byte whose pointer lies in `WIN_LO`..`WIN_HI` (0x20..0x39 by default) is acknowledged. It is written with exactly one single-cycle `reg_we` pulse, with `reg_addr` equal to the pointer.
- R4: A data byte whose pointer lies outside the window is not acknowledged, and no register is written.
- R5: After each acknowledged data byte, the pointer advances by one, so a burst writes consecutive locations.
- R6: After an address with the read bit (bit 0 = 1), the block acknowledges and sends the byte at the pointer, MSB first. The pointer advances after every byte sent. Each host ACK starts the next byte.
- R7: When the host answers a read byte with NACK, SDA stays released until the next START.
- R8: The pointer keeps its value across STOP and START and across repeated START. A read without a new pointer write begins at the last pointer that was set.
- R9: Each read byte is sampled from the register file when its first bit is driven, not when an earlier byte was sent.
- R10: The pointer wraps from 0x7F to 0x00.
- R11: A START or STOP in the middle of a byte abandons that byte without storing it. A START returns the block to the address phase.
- R12: `sda_oe` and `reg_addr` change only while SCL is low. The acknowledge drive is removed after the falling edge of the ninth clock.
- R13: After reset, SDA is released, `reg_we` is low and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | ADDR_W | Register pointer, used as the register-file address |
| reg_wdata | output | 8 | Byte to store |
| reg_we | output | 1 | Single-cycle store strobe |
| reg_rdata | input | 8 | Register-file data at `reg_addr` |

## Verification
The assertions assume a well-formed host. SCL stays low for several system clocks around every falling edge. The host never issues START or STOP while the target holds SDA low. SDA changes only with SCL low, except for START and STOP. The bench drives every bit with SCL phases of eight clocks, moves SDA two clocks after each SCL fall, and finishes each read with a NACK before it sends STOP. Random transfers are drawn only from legal frame shapes: writes, reads, write-then-repeated-START reads and foreign addresses, with random pointers and lengths.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } rs_state_t;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_s, scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rs_ptr.sv
module i2c_rs_ptr #(
  parameter int              ADDR_W = 7,
  parameter logic [ADDR_W-1:0] WIN_LO = 7'h20,
  parameter logic [ADDR_W-1:0] WIN_HI = 7'h39
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] ptr,
  output logic              in_win
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr + 1'b1;
  end

  assign in_win = (ptr >= WIN_LO) && (ptr <= WIN_HI);
endmodule

// File: rtl/i2c_rs_fsm.sv
module i2c_rs_fsm
  import i2c_rs_pkg::*;
#(
  parameter int              ADDR_W   = 7,
  parameter logic [6:0]      DEV_ADDR = 7'h1B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              in_win,
  input  logic [7:0]        reg_rdata,
  output logic              ptr_load,
  output logic [ADDR_W-1:0] ptr_load_val,
  output logic              ptr_inc,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [7:0]        reg_wdata
);
  localparam int BITS = 8;
  localparam logic [3:0] LAST = 4'(BITS);

  rs_state_t  state;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [7:0] tx;
  logic       rd_mode;
  logic       acked;
  logic       host_ack;
  logic       bus_evt;

  assign bus_evt      = start_det | stop_det;
  assign ptr_load_val = sh[ADDR_W-1:0];

  always_comb begin
    ptr_load = 1'b0;
    ptr_inc  = 1'b0;
    if (!bus_evt && scl_fall) begin
      case (state)
        ST_PTR_ACK: ptr_load = acked;
        ST_WR_ACK:  ptr_inc  = acked;
        ST_RD:      ptr_inc  = (cnt == LAST);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      rd_mode   <= 1'b0;
      acked     <= 1'b0;
      host_ack  <= 1'b0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_WR: begin
            if (scl_rise && cnt < LAST) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rd_mode <= sh[0];
                  sda_oe  <= 1'b1;
                  state   <= ST_ADDR_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_PTR) begin
                acked  <= (sh[7:ADDR_W] == '0);
                sda_oe <= (sh[7:ADDR_W] == '0);
                state  <= ST_PTR_ACK;
              end else begin
                acked     <= in_win;
                sda_oe    <= in_win;
                reg_we    <= in_win;
                reg_wdata <= sh;
                state     <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            if (rd_mode) begin
              tx     <= reg_rdata;
              sda_oe <= ~reg_rdata[7];
              state  <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_PTR;
            end
          end
          ST_PTR_ACK, ST_WR_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= acked ? ST_WR : ST_SKIP;
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                state  <= ST_RD_ACK;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (host_ack) begin
                tx     <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
                state  <= ST_RD;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter int              SYNC_STAGES = 2,
  parameter int              ADDR_W      = 7,
  parameter logic [6:0]      DEV_ADDR    = 7'h1B,
  parameter logic [ADDR_W-1:0] WIN_LO    = 7'h20,
  parameter logic [ADDR_W-1:0] WIN_HI    = 7'h39
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              reg_we,
  input  logic [7:0]        reg_rdata
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ptr_load, ptr_inc, in_win;
  logic [ADDR_W-1:0] ptr_load_val;

  i2c_rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rs_ptr #(.ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(ptr_load_val),
    .inc(ptr_inc), .ptr(reg_addr), .in_win(in_win)
  );

  i2c_rs_fsm #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .in_win(in_win), .reg_rdata(reg_rdata), .ptr_load(ptr_load),
    .ptr_load_val(ptr_load_val), .ptr_inc(ptr_inc), .sda_oe(sda_oe),
    .reg_we(reg_we), .reg_wdata(reg_wdata)
  );
endmodule

// File: rtl/i2c_rs_chk.sv
module i2c_rs_chk #(
  parameter int              ADDR_W = 7,
  parameter logic [ADDR_W-1:0] WIN_LO = 7'h20,
  parameter logic [ADDR_W-1:0] WIN_HI = 7'h39
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr
);
  // R4: a store strobe only ever targets the writable window
  p_we_window_r4: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (reg_addr >= WIN_LO && reg_addr <= WIN_HI));

  // R3: one strobe cycle per stored byte
  p_we_single_r3: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R12: the SDA drive moves only while SCL is low
  p_sda_edge_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);

  // R5: the pointer moves only while SCL is low
  p_ptr_edge_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(reg_addr) |-> !scl_i);
endmodule

bind i2c_regslave i2c_rs_chk #(.ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/sim_i2c_regslave.sv
module sim_i2c_regslave;
  localparam logic [6:0] DEV = 7'h1B;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_h = 1'b1;
  logic sda;
  logic sda_oe, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];
  logic [6:0] exp_ptr;
  logic poke_req = 1'b0;
  logic [6:0] poke_a = '0;
  logic [7:0] poke_v = '0;

  int checks = 0;
  int errors = 0;
  int viol = 0;
  logic prev_oe = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;
  assign sda = sda_h & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_regslave u0 (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 37 + 11) ^ 8'h5A);
  endfunction

  function automatic bit in_win(logic [6:0] p);
    return p >= 7'h20 && p <= 7'h39;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 128; i++) mem[i] <= init_val(i);
    end else begin
      if (reg_we) mem[reg_addr] <= reg_wdata;
      if (poke_req) mem[poke_a] <= poke_v;
    end
  end

  // R12 bench monitor: the drive changes only with SCL low
  always @(posedge clk) begin
    if (!rst && sda_oe != prev_oe && scl) viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_h = 1'b1; scl = 1'b1; wt(Q);
    sda_h = 1'b0; wt(Q);
    scl = 1'b0;
  endtask

  task automatic bus_rstart;
    wt(2); sda_h = 1'b1; wt(Q);
    scl = 1'b1; wt(Q);
    sda_h = 1'b0; wt(Q);
    scl = 1'b0;
  endtask

  task automatic bus_stop;
    wt(2); sda_h = 1'b0; wt(Q);
    scl = 1'b1; wt(Q);
    sda_h = 1'b1; wt(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      wt(2); sda_h = b[i]; wt(Q);
      scl = 1'b1; wt(Q);
      scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    wt(2); sda_h = 1'b1; wt(Q);
    scl = 1'b1; wt(Q / 2);
    ack = !sda; wt(Q / 2);
    scl = 1'b0;
  endtask

  task automatic recv_byte(input bit hack, input bit poke, input logic [6:0] pa,
                           input logic [7:0] pv, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wt(2); sda_h = 1'b1; wt(Q);
      scl = 1'b1; wt(Q / 2);
      b[i] = sda; wt(Q / 2);
      scl = 1'b0;
    end
    if (poke) begin
      poke_a = pa; poke_v = pv; poke_req = 1'b1; wt(1);
      poke_req = 1'b0;
      exp_mem[pa] = pv;
    end
    wt(2); sda_h = !hack; wt(Q);
    scl = 1'b1; wt(Q);
    scl = 1'b0;
  endtask

  // write pointer p, then n data bytes
  task automatic do_write(input logic [7:0] p, input int n, input bit fin);
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    chk(a == 1'b1, "R1", a, 1);
    send_byte(p, a);
    chk(a == (p < 8'h80), "R2", a, p < 8'h80);
    if (a) begin
      exp_ptr = p[6:0];
      for (int k = 0; k < n; k++) begin
        d = 8'($urandom);
        send_byte(d, a);
        chk(a == in_win(exp_ptr), in_win(exp_ptr) ? "R3" : "R4", a, in_win(exp_ptr));
        if (!a) break;
        exp_mem[exp_ptr] = d;
        exp_ptr = exp_ptr + 1'b1;
      end
    end
    if (fin) bus_stop();
  endtask

  task automatic do_read(input int n, input bit rs, input string tag,
                         input bit poke);
    bit a;
    logic [7:0] b;
    if (rs) bus_rstart(); else bus_start();
    send_byte({DEV, 1'b1}, a);
    chk(a == 1'b1, "R1", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, poke && k == 0, exp_ptr + 1'b1, 8'hC3, b);
      chk(b == exp_mem[exp_ptr], tag, b, exp_mem[exp_ptr]);
      exp_ptr = exp_ptr + 1'b1;
    end
    wt(4);
    chk(sda_oe == 1'b0, "R7", sda_oe, 0);
    bus_stop();
  endtask

  task automatic foreign;
    bit a;
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, a);
    chk(a == 1'b0, "R1", a, 0);
    send_byte(8'h22, a);
    chk(a == 1'b0, "R1", a, 0);
    bus_stop();
  endtask

  initial begin
    bit a;
    void'($urandom(32'd4321));
    for (int i = 0; i < 128; i++) exp_mem[i] = init_val(i);
    exp_ptr = '0;
    wt(5);
    rst = 1'b0;
    wt(2);
    // R13 reset state
    chk(sda_oe == 1'b0, "R13", sda_oe, 0);
    chk(reg_we == 1'b0, "R13", reg_we, 0);
    chk(reg_addr == 7'h00, "R13", reg_addr, 0);
    wt(Q);

    do_read(2, 0, "R13", 0);                  // pointer starts at 0
    do_write(8'h38, 3, 1);                     // 0x38,0x39 stored, 0x3A refused (R4)
    do_write(8'h38, 0, 0);
    do_read(3, 1, "R5", 0);                    // R5 consecutive bytes
    do_write(8'h10, 1, 1);                     // R4 refused outside window
    do_write(8'h85, 0, 1);                     // R2 pointer refused
    do_read(1, 0, "R2", 0);                    // pointer kept after refusal
    do_read(2, 0, "R8", 0);                    // R8 continue from kept pointer
    do_write(8'h7E, 0, 0);
    do_read(3, 1, "R10", 0);                   // R10 wrap 0x7F -> 0x00
    do_write(8'h50, 0, 0);
    do_read(2, 1, "R9", 1);                    // R9 second byte poked late
    foreign();                                 // R1 foreign address

    // R11: STOP in the middle of a data byte
    do_write(8'h25, 0, 0);
    send_bits(8'hFF, 4);
    bus_stop();
    do_read(1, 0, "R11", 0);
    // R11: repeated START in the middle of a data byte
    do_write(8'h30, 0, 0);
    send_bits(8'h0F, 3);
    do_read(1, 1, "R11", 0);

    for (int it = 0; it < 40; it++) begin
      int r;
      r = $urandom_range(0, 3);
      case (r)
        0: do_write($urandom_range(0, 1) ? 8'($urandom_range(8'h1C, 8'h40))
                                          : 8'($urandom), $urandom_range(1, 4), 1);
        1: do_read($urandom_range(1, 4), 0, "R6", 0);
        2: begin
          do_write(8'($urandom_range(0, 127)), 0, 0);
          do_read($urandom_range(1, 4), 1, "R8", 0);
        end
        default: foreign();
      endcase
    end

    chk(viol == 0, "R12", viol, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule